// File: doc/BRIEF.md
# Serial Register Bank Slave

This block is the device end of a three-wire serial programming link. A host frames each transfer with an active-high enable line and clocks 32 bits on a serial clock. The first bit is a direction flag. Six address bits follow, and then 24 data bits. Behind the link is a bank of 64 registers, each 24 bits wide. The full contents of the bank are driven onto a parallel output bus, so the logic that uses the settings can read them directly.

In a write frame the slave collects the data word and stores it in the addressed register, but only on the last rising clock edge of the frame. In a read frame the slave takes over its single output pin and shifts the addressed register out on it, most significant bit first. At all other times the pin passes through a status input, such as a lock indication.

The serial clock, enable and data inputs are oversampled by the system clock through two-flop synchronizers. The system clock must run at least four times as fast as the serial clock.

Top module: `serreg_slave`

## Requirements
- R1: After reset every register in the bank reads zero on `regs_flat`, and `sdo_ld` follows `lock_det`.
- R2: The level of `sdi` at the first rising `sck` edge after `sen` goes high selects the direction: 1 means read, 0 means write.
- R3: On rising edges 2 to 7, `sdi` carries the 6-bit register address, most significant bit first. Register n occupies `regs_flat[24*n+23 : 24*n]`.
- R4: In a write, rising edges 8 to 31 carry the 24-bit data word, most significant bit first. The addressed register takes this word on rising edge 32 and not before, so after edge 31 it still holds its old value.
- R5: In a read, from rising edge 8+k (k = 0..23) until the next rising edge, `sdo_ld` shows bit 23-k of the addressed register.
- R6: Outside the read data window, `sdo_ld` equals `lock_det`. This includes the flag and address edges of a read and the time after edge 32 while `sen` is still high.
- R7: If `sen` falls before edge 32, the frame is dropped: no register changes and `sdo_ld` returns to `lock_det`.
- R8: Rising edges after the 32nd within one enable window have no effect, and the next frame decodes normally.
- R9: A read frame never changes any register, whatever `sdi` carries during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| sen | input | 1 | Frame enable from the host, active high |
| sdi | input | 1 | Serial data from the host |
| lock_det | input | 1 | Status signal passed to the shared output outside read data |
| sdo_ld | output | 1 | Shared pin: read data during a read, status otherwise |
| regs_flat | output | 1536 | All 64 registers side by side, register n at bits 24n+23:24n |

## Verification
The assertions assume that every level of `sck` lasts long enough to survive the synchronizers. They also assume that `sdi` is stable around each rising `sck` edge, and that `sen` changes only while `sck` is low. Under these conditions the synchronized edge count matches the host's count. The stimulus holds each serial clock phase for eight system clocks. It changes `sdi`, `sen` and `lock_det` only during the low phase, at the falling edge of the system clock.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

  // Role of the next rising serial clock edge within a frame
  typedef enum logic [2:0] {
    PH_FLAG,
    PH_ADDR,
    PH_DATA,
    PH_COMMIT,
    PH_SPENT
  } phase_e;

  // Total rising edges in one frame: flag + address + data + commit
  function automatic int frame_len(input int aw, input int dw);
    return aw + dw + 2;
  endfunction

  // Map the number of edges already seen to the role of the next edge
  function automatic phase_e phase_of(input int seen, input int aw, input int dw);
    if (seen == 0)              return PH_FLAG;
    else if (seen <= aw)        return PH_ADDR;
    else if (seen <= aw + dw)   return PH_DATA;
    else if (seen == aw + dw + 1) return PH_COMMIT;
    else                        return PH_SPENT;
  endfunction

endpackage

// File: rtl/serreg_rst_sync.sv
module serreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/serreg_frame.sv
module serreg_frame
  import serreg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sen_act,
  input  logic              sck_rise,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_drive,
  output logic              rd_bit
);

  localparam int FRAME_LEN = frame_len(ADDR_W, DATA_W);
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rw_q, rw_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              rd_q, rd_d;
  phase_e            phase;

  // Next-state decode of one frame
  always_comb begin
    cnt_d   = cnt_q;
    rw_d    = rw_q;
    addr_d  = addr_q;
    shift_d = shift_q;
    rd_d    = rd_q;
    wr_en   = 1'b0;
    phase   = phase_of(int'(cnt_q), ADDR_W, DATA_W);
    if (!sen_act) begin
      cnt_d = '0;
      rd_d  = 1'b0;
    end else if (sck_rise) begin
      case (phase)
        PH_FLAG: begin
          rw_d  = sdi_s;
          cnt_d = cnt_q + CNT_ONE;
        end
        PH_ADDR: begin
          addr_d = {addr_q[ADDR_W-2:0], sdi_s};
          cnt_d  = cnt_q + CNT_ONE;
        end
        PH_DATA: begin
          cnt_d = cnt_q + CNT_ONE;
          if (rw_q) begin
            if (!rd_q) begin
              shift_d = rd_word;
              rd_d    = 1'b1;
            end else begin
              shift_d = {shift_q[DATA_W-2:0], 1'b0};
            end
          end else begin
            shift_d = {shift_q[DATA_W-2:0], sdi_s};
          end
        end
        PH_COMMIT: begin
          cnt_d = cnt_q + CNT_ONE;
          rd_d  = 1'b0;
          wr_en = !rw_q;
        end
        default: begin
          cnt_d = cnt_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
      shift_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rw_q    <= rw_d;
      addr_q  <= addr_d;
      shift_q <= shift_d;
      rd_q    <= rd_d;
    end
  end

  assign addr_o   = addr_q;
  assign wr_data  = shift_q;
  assign rd_drive = rd_q;
  assign rd_bit   = shift_q[DATA_W-1];

  // R8: the edge count saturates at the frame length
  p_cnt_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= FRAME_LEN);

  // R5: the pin carries data only inside the read data window
  p_read_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |-> (rw_q && int'(cnt_q) >= ADDR_W + 2 && int'(cnt_q) <= ADDR_W + DATA_W + 1));

  // R6: once the last edge has passed, status owns the pin again
  p_end_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_q) >= FRAME_LEN) |-> !rd_q);

  // R7: a dropped enable clears the frame state on the next cycle
  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_act |=> (cnt_q == '0 && !rd_q));

  // R2: the direction flag holds for the rest of the frame
  p_flag_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_act && int'(cnt_q) >= 2) |-> $stable(rw_q));

  // R4: one commit per frame
  p_single_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

// File: rtl/serreg_bank.sv
module serreg_bank #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 24
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [DATA_W-1:0]                  rd_word,
  output logic [(1<<ADDR_W)*DATA_W-1:0]      regs_flat
);

  localparam int NREG = 1 << ADDR_W;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] val_q, val_d;

    assign hit = wr_en && (addr == ADDR_W'(i));

    always_comb begin
      val_d = hit ? wr_data : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= val_d;
    end

    assign regs_flat[i*DATA_W +: DATA_W] = val_q;
  end

  assign rd_word = regs_flat[addr*DATA_W +: DATA_W];

  // R9: with no commit pending the bank keeps its contents
  p_hold_without_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

  // R4: a commit leaves the addressed register holding the word
  p_commit_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_word == $past(wr_data) || addr != $past(addr)));

endmodule

// File: rtl/serreg_slave.sv
module serreg_slave #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2,
  localparam int NREG       = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sck,
  input  logic                   sen,
  input  logic                   sdi,
  input  logic                   lock_det,
  output logic                   sdo_ld,
  output logic [NREG*DATA_W-1:0] regs_flat
);

  logic              rst_s_n;
  logic [2:0]        pins_s;
  logic              sen_s, sck_s, sdi_s;
  logic              sck_prev_q, sck_prev_d;
  logic              sck_rise;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_word;
  logic              rd_drive;
  logic              rd_bit;

  serreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  serreg_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .din   ({sen, sck, sdi}),
    .dout  (pins_s)
  );

  assign {sen_s, sck_s, sdi_s} = pins_s;

  always_comb begin
    sck_prev_d = sck_s;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) sck_prev_q <= 1'b0;
    else          sck_prev_q <= sck_prev_d;
  end

  assign sck_rise = sck_s && !sck_prev_q;

  serreg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .sen_act  (sen_s),
    .sck_rise (sck_rise),
    .sdi_s    (sdi_s),
    .rd_word  (rd_word),
    .addr_o   (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_drive (rd_drive),
    .rd_bit   (rd_bit)
  );

  serreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_word   (rd_word),
    .regs_flat (regs_flat)
  );

  assign sdo_ld = rd_drive ? rd_bit : lock_det;

  // R6 / R7: with the enable low for two cycles the pin shows status
  p_idle_status_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!sen_s && $past(!sen_s)) |-> (sdo_ld == lock_det));

endmodule

// File: tb/test_serreg_slave.sv
module test_serreg_slave;

  localparam int AW = 6;
  localparam int DW = 24;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, sck, sen, sdi, lock_det;
  logic sdo_ld;
  logic [NR*DW-1:0] regs_flat;

  int checks = 0;
  int errors = 0;
  int status_bad = 0;
  logic [DW-1:0] at_edge31;

  always #10 clk = ~clk;

  serreg_slave #(.ADDR_W(AW), .DATA_W(DW)) i_serreg_slave (
    .clk (clk), .rst_n (rst_n), .sck (sck), .sen (sen), .sdi (sdi),
    .lock_det (lock_det), .sdo_ld (sdo_ld), .regs_flat (regs_flat)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 32'h0003_5AC7 + 32'h005A_5A5A) ^ (a << 17));
  endfunction

  function automatic logic [DW-1:0] reg_of(input int a);
    return regs_flat[a*DW +: DW];
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // One frame of n_edges rising edges; sen drops afterwards
  task automatic frame(input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int n_edges, output logic [DW-1:0] got);
    got = '0;
    @(negedge clk);
    sen = 1'b1;
    sdi = rd;
    hold(8);
    for (int k = 1; k <= n_edges; k++) begin
      @(negedge clk);
      lock_det = ~lock_det;
      if (k == 1)       sdi = rd;
      else if (k <= 7)  sdi = a[7-k];
      else if (k <= 31) sdi = d[31-k];
      else              sdi = 1'b1;
      hold(8);
      sck = 1'b1;
      hold(8);
      if (rd && k >= 8 && k <= 31) got[31-k] = sdo_ld;
      else if (sdo_ld !== lock_det) status_bad++;
      if (k == 31) at_edge31 = reg_of(int'(a));
      @(negedge clk);
      sck = 1'b0;
    end
    hold(8);
    sen = 1'b0;
    hold(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    logic [DW-1:0] old;
    rst_n = 1'b0; sck = 1'b0; sen = 1'b0; sdi = 1'b0; lock_det = 1'b0;
    hold(5);
    rst_n = 1'b1;
    hold(6);

    // R1: reset contents and status pass-through
    for (int a = 0; a < NR; a++) chk("R1 reset value", reg_of(a), '0);
    chk("R1 status low", DW'(sdo_ld), DW'(1'b0));
    lock_det = 1'b1; #1;
    chk("R1 status high", DW'(sdo_ld), DW'(1'b1));

    // R3 R4: write every address; register unchanged after edge 31
    for (int a = 0; a < NR; a++) begin
      old = reg_of(a);
      frame(1'b0, AW'(a), pat(a), 32, got);
      chk("R4 held until edge 32", at_edge31, old);
    end
    for (int a = 0; a < NR; a++) chk("R3 R4 written word", reg_of(a), pat(a));
    chk("R6 status during writes", DW'(status_bad), '0);

    // R2 R5 R9: read every address, sdi driven with ones during data
    status_bad = 0;
    for (int a = 0; a < NR; a++) begin
      frame(1'b1, AW'(a), '1, 32, got);
      chk("R5 read word", got, pat(a));
    end
    chk("R6 status outside read window", DW'(status_bad), '0);
    for (int a = 0; a < NR; a++) chk("R9 R2 read leaves bank", reg_of(a), pat(a));

    // R7: aborted write
    frame(1'b0, AW'(5), 24'hC3C3C3, 20, got);
    chk("R7 aborted write", reg_of(5), pat(5));
    frame(1'b0, AW'(6), 24'h0F0F0F, 31, got);
    chk("R7 abort at edge 31", reg_of(6), pat(6));
    // R7: aborted read returns pin to status
    frame(1'b1, AW'(7), '0, 15, got);
    lock_det = 1'b0; #1;
    chk("R7 pin after aborted read low", DW'(sdo_ld), DW'(1'b0));
    lock_det = 1'b1; #1;
    chk("R7 pin after aborted read high", DW'(sdo_ld), DW'(1'b1));

    // R8: surplus edges ignored, next frame normal
    status_bad = 0;
    frame(1'b0, AW'(9), 24'h800001, 38, got);
    chk("R8 write with surplus edges", reg_of(9), 24'h800001);
    chk("R8 status on surplus edges", DW'(status_bad), '0);
    frame(1'b1, AW'(10), '0, 32, got);
    chk("R8 next frame read", got, pat(10));
    frame(1'b1, AW'(9), '0, 36, got);
    chk("R8 read with surplus edges", got, 24'h800001);

    // R3 R5: boundary addresses with walking patterns
    frame(1'b0, AW'(NR-1), 24'h000001, 32, got);
    frame(1'b1, AW'(NR-1), '0, 32, got);
    chk("R5 lsb only at top address", got, 24'h000001);
    frame(1'b0, AW'(0), 24'h800000, 32, got);
    frame(1'b1, AW'(0), '0, 32, got);
    chk("R3 msb only at address 0", got, 24'h800000);
    chk("R3 neighbour untouched", reg_of(1), pat(1));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule